// File: doc/BRIEF.md
# Software Inter-Processor Interrupt Controller

This block carries inter-processor interrupts among a group of up to eight harts. A hart raises an interrupt at another hart by writing a single bit into its own slice of a shared pending array. Every pending bit is an interrupt source with a programmable priority. Each target hart has a context that holds a per-source enable mask and a claim/complete register. The block drives one interrupt line per target hart.

A target hart handles an interrupt in two steps. It reads its claim register, which returns the best eligible source ID and clears that source's pending bit in the same access. When the handler is done, it writes the same ID back to that register. While a claim is outstanding, the hart's interrupt line stays low. The block sits on a simple 32-bit register bus with one request strobe, a write flag, and a response one cycle later.

Top module: `sipi_ctrl`

## Requirements
- R1: The pending array is write-one-to-set. Word w sits at byte offset 0x1000 + 4*w. A sender hart h with target y owns bit 8*(h mod 4) + y of word h/4. Writing 0 to a bit leaves it unchanged, and no write clears a bit. Reads return the current pending word.
- R2: A source's ID is 8*sender + target + 1, which is its overall pending bit index plus one. Its priority lives at offset 4*ID and is PRIO_W bits wide (3 by default). The upper bits read as zero. A source with priority 0 is never delivered or claimed.
- R3: Target t has two enable words, at offsets 0x2000 + 0x80*t and 0x2000 + 0x80*t + 4. Bit k of word w enables the source with bit index 32*w + k. A source that is not enabled for a target does not reach it. Both enable words read back as written.
- R4: A read of the claim register of target t, at offset 0x4000 + 0x100*t + 4, returns the ID of the pending, enabled, nonzero-priority source with the highest priority. The same read clears that source's pending bit. The read returns 0 when no source is eligible.
- R5: When eligible sources share the highest priority, the claim returns the lowest ID among them.
- R6: Writing the outstanding claimed ID to the same claim register completes the interrupt. A write with any other ID is ignored, and the claim stays outstanding.
- R7: irq_o[t] is high exactly when target t has an eligible pending source and no outstanding claim. A claim read while a claim is outstanding returns 0 and clears nothing. A source that becomes pending again while claimed is delivered after the claim completes.
- R8: Every request, read or write, is answered by rsp_valid_o high in the next cycle. For a read, rdata_o carries the read data in that cycle. For a write, rdata_o is zero.
- R9: Reads of unmapped offsets return 0, and writes to them change nothing. Unmapped offsets include priority ID 0, pending words beyond the array, enable words beyond the second, and context offsets other than +4.
- R10: After reset, all pending bits, priorities and enables are zero, no claim is outstanding, and all irq_o lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte offset from the block base |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rdata_o | output | 32 | Read data, valid with rsp_valid_o |
| irq_o | output | NUM_HARTS | Interrupt line per target hart |

## Verification
Claim arbitration is tested with three source patterns:
- **Unequal priorities.** Two sources with different priorities are pending at one target. The claim must pick by priority and not by ID order.
- **Equal priorities.** Two sources with equal priority are pending. The claim must pick by ID.
- **Ineligible sources.** Sources that have zero priority or are not enabled are pending. This shows whether the priority and enable masks gate delivery.

The handshake tests cover:
- a second claim while one is outstanding;
- a mismatched complete;
- a source raised again during its own claim.

Together these separate the busy gating of the interrupt line from the clearing of pending bits. Finally, writes of zeros and writes to unmapped offsets are followed by read-backs. These show that nothing can clear or corrupt state through those paths.

// File: rtl/sipi_pkg.sv
package sipi_pkg;

    localparam int SLICE_W  = 8;
    localparam int MAX_SRC  = 64;
    localparam int SRC_IW   = $clog2(MAX_SRC);
    localparam int ID_W     = SRC_IW + 1;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;

    localparam logic [3:0] PAGE_PRIO = 4'h0;
    localparam logic [3:0] PAGE_PEND = 4'h1;
    localparam logic [3:0] PAGE_EN   = 4'h2;
    localparam logic [3:0] PAGE_CTX  = 4'h4;
    localparam logic [7:0] CLAIM_OFS = 8'h04;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e     rg;
        logic [9:0]  idx;
        logic [4:0]  tgt;
        logic        word;
    } dec_t;

    // Map a byte offset onto a register region; anything out of range is RG_NONE.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nh);
        dec_t d;
        int   nsrc;
        nsrc   = SLICE_W * nh;
        d.rg   = RG_NONE;
        d.idx  = a[11:2];
        d.tgt  = '0;
        d.word = 1'b0;
        case (a[15:12])
            PAGE_PRIO: if (a[11:2] != 10'd0 && int'(a[11:2]) <= nsrc) d.rg = RG_PRIO;
            PAGE_PEND: if (int'(a[11:2]) < (nsrc + 31) / 32) d.rg = RG_PEND;
            PAGE_EN: if (int'(a[11:7]) < nh && a[6:3] == 4'd0) begin
                d.rg   = RG_EN;
                d.tgt  = a[11:7];
                d.word = a[2];
            end
            PAGE_CTX: if (int'(a[11:8]) < nh && a[7:0] == CLAIM_OFS) begin
                d.rg  = RG_CLAIM;
                d.tgt = {1'b0, a[11:8]};
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sipi_arbiter.sv
module sipi_arbiter
    import sipi_pkg::*;
#(
    parameter int N      = MAX_SRC,
    parameter int PRIO_W = 3
) (
    input  logic [N-1:0]        cand,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic [ID_W-1:0]     win_id
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare: zero priority never wins, ties keep the lower ID.
    always_comb begin
        best_p = '0;
        win_id = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && prio_flat[i*PRIO_W +: PRIO_W] > best_p) begin
                best_p = prio_flat[i*PRIO_W +: PRIO_W];
                win_id = ID_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/sipi_ctx.sv
module sipi_ctx
    import sipi_pkg::*;
#(
    parameter int SRC = MAX_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic              en_word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    input  logic [ID_W-1:0]   take_id,
    input  logic              cmpl,
    input  logic [SRC-1:0]    elig,
    output logic [SRC-1:0]    en_o,
    output logic              busy_o,
    output logic              irq_o
);

    logic [SRC-1:0]  en_q;
    logic            busy_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            busy_q <= 1'b0;
            id_q   <= '0;
        end else begin
            if (en_we) en_q[en_word*32 +: 32] <= wdata;
            if (take) begin
                busy_q <= 1'b1;
                id_q   <= take_id;
            end else if (cmpl && busy_q && wdata == DATA_W'(id_q)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign en_o   = en_q;
    assign busy_o = busy_q;
    assign irq_o  = (|(elig & en_q)) && !busy_q;

    AST_BAD_COMPLETE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cmpl && busy_q && wdata != DATA_W'(id_q)) |=> busy_q); // R6
    AST_TAKE_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        take |-> !busy_q); // R7

endmodule

// File: rtl/sipi_ctrl.sv
module sipi_ctrl
    import sipi_pkg::*;
#(
    parameter int NUM_HARTS = 8,
    parameter int PRIO_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic [15:0]          addr_i,
    input  logic [31:0]          wdata_i,
    output logic                 rsp_valid_o,
    output logic [31:0]          rdata_o,
    output logic [NUM_HARTS-1:0] irq_o
);

    localparam int NSRC = SLICE_W * NUM_HARTS;
    localparam int HW   = $clog2(NUM_HARTS);
    localparam logic [MAX_SRC-1:0] SRC_MASK =
        (NSRC >= MAX_SRC) ? {MAX_SRC{1'b1}} : ((MAX_SRC'(1) << NSRC) - MAX_SRC'(1));

    logic [MAX_SRC-1:0]        pend_q;
    logic [MAX_SRC*PRIO_W-1:0] prio_q;
    logic [MAX_SRC-1:0]        nz;
    logic [MAX_SRC-1:0]        elig;
    logic [MAX_SRC-1:0]        en_all [NUM_HARTS];
    logic [NUM_HARTS-1:0]      busy;
    logic [MAX_SRC-1:0]        cand;
    logic [ID_W-1:0]           win_id;
    logic [ID_W-1:0]           win_m1;
    logic [9:0]                idx_m1;
    logic [SRC_IW-1:0]         pidx;
    logic [HW-1:0]             tsel;
    logic [DATA_W-1:0]         rd_d;
    logic                      wr, rd, claim_ok;
    dec_t                      dec;

    assign dec    = decode_addr(addr_i, NUM_HARTS);
    assign wr     = req_i && we_i;
    assign rd     = req_i && !we_i;
    assign tsel   = dec.tgt[HW-1:0];
    assign idx_m1 = dec.idx - 10'd1;
    assign pidx   = idx_m1[SRC_IW-1:0];
    assign win_m1 = win_id - ID_W'(1);

    for (genvar g = 0; g < MAX_SRC; g++) begin : g_nz
        assign nz[g] = |prio_q[g*PRIO_W +: PRIO_W];
    end
    assign elig = pend_q & nz;
    assign cand = pend_q & en_all[tsel];

    sipi_arbiter #(.N(MAX_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand      (cand),
        .prio_flat (prio_q),
        .win_id    (win_id)
    );

    assign claim_ok = rd && dec.rg == RG_CLAIM && !busy[tsel] && win_id != '0;

    for (genvar t = 0; t < NUM_HARTS; t++) begin : g_ctx
        sipi_ctx #(.SRC(MAX_SRC)) u_ctx (
            .clk     (clk),
            .rst     (rst),
            .en_we   (wr && dec.rg == RG_EN && tsel == HW'(t)),
            .en_word (dec.word),
            .wdata   (wdata_i),
            .take    (claim_ok && tsel == HW'(t)),
            .take_id (win_id),
            .cmpl    (wr && dec.rg == RG_CLAIM && tsel == HW'(t)),
            .elig    (elig),
            .en_o    (en_all[t]),
            .busy_o  (busy[t]),
            .irq_o   (irq_o[t])
        );
    end

    always_comb begin
        case (dec.rg)
            RG_PRIO:  rd_d = DATA_W'(prio_q[pidx*PRIO_W +: PRIO_W]);
            RG_PEND:  rd_d = pend_q[dec.idx[0]*32 +: 32];
            RG_EN:    rd_d = en_all[tsel][dec.word*32 +: 32];
            RG_CLAIM: rd_d = claim_ok ? DATA_W'(win_id) : '0;
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            prio_q      <= '0;
            rsp_valid_o <= 1'b0;
            rdata_o     <= '0;
        end else begin
            rsp_valid_o <= req_i;
            rdata_o     <= rd ? rd_d : '0;
            if (wr && dec.rg == RG_PEND)
                pend_q[dec.idx[0]*32 +: 32] <= pend_q[dec.idx[0]*32 +: 32]
                                               | (wdata_i & SRC_MASK[dec.idx[0]*32 +: 32]);
            if (wr && dec.rg == RG_PRIO)
                prio_q[pidx*PRIO_W +: PRIO_W] <= wdata_i[PRIO_W-1:0];
            if (claim_ok)
                pend_q[win_m1[SRC_IW-1:0]] <= 1'b0;
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_i |=> rsp_valid_o); // R8
    AST_PEND_FALLS_ONLY_ON_CLAIM: assert property (@(posedge clk) disable iff (rst)
        !claim_ok |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R1
    AST_CLAIM_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
        claim_ok |=> ($countones(pend_q) + 1 == $past($countones(pend_q)))); // R4
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> (irq_o == '0)); // R7

endmodule

// File: tb/test_sipi_ctrl.sv
module test_sipi_ctrl;

    localparam int NH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [15:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rdata;
    logic [NH-1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sipi_ctrl #(.NUM_HARTS(NH), .PRIO_W(3)) i_sipi_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .we_i        (we),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rsp_valid_o (rsp_valid),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [15:0] a, input logic [31:0] d,
                       output logic [31:0] q);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        q = rdata;
        chk("R8 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    endtask

    task automatic wr32(input logic [15:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus(1'b1, a, d, q);
        chk("R8 write rdata zero", q, 32'd0);
    endtask

    task automatic rd_chk(input string r, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] q;
        bus(1'b0, a, 32'd0, q);
        chk(r, q, exp);
    endtask

    // Offsets: claim of target t at 0x4000+0x100*t+4; enables at 0x2000+0x80*t.
    task automatic t_reset;
        chk("R10 irq after reset", 32'(irq), 32'd0);
        rd_chk("R10 pending word0", 16'h1000, 32'd0);
        rd_chk("R10 priority ID1", 16'h0004, 32'd0);
        rd_chk("R10 claim ctx0 empty", 16'h4004, 32'd0);
    endtask

    task automatic t_w1s;
        wr32(16'h1000, 32'h0000_0400);             // sender 1 -> target 2, ID 11
        rd_chk("R1 set bit", 16'h1000, 32'h0000_0400);
        wr32(16'h1000, 32'h0000_0000);
        rd_chk("R1 zero write keeps bit", 16'h1000, 32'h0000_0400);
        wr32(16'h1000, 32'h0000_0008);             // sender 0 -> target 3, ID 4
        rd_chk("R1 second bit ORs in", 16'h1000, 32'h0000_0408);
        chk("R2 no irq without priority", 32'(irq), 32'd0);
        wr32(16'h002C, 32'd1);                     // priority of ID 11
        chk("R3 no irq without enable", 32'(irq), 32'd0);
        wr32(16'h2100, 32'h0000_0400);             // ctx2 enable bit 10
        chk("R7 irq2 raised", 32'(irq), 32'h04);
        rd_chk("R3 enable readback", 16'h2100, 32'h0000_0400);
        wr32(16'h2180, 32'h0000_0008);             // ctx3 enables ID 4 (priority 0)
        chk("R2 zero priority no irq3", 32'(irq), 32'h04);
        rd_chk("R2 zero priority not claimable", 16'h4304, 32'd0);
        rd_chk("R2 pending intact", 16'h1000, 32'h0000_0408);
    endtask

    task automatic t_claim;
        wr32(16'h00AC, 32'd5);                     // priority of ID 43
        wr32(16'h2104, 32'h0000_0400);             // ctx2 enable bit 42
        wr32(16'h1004, 32'h0000_0400);             // sender 5 -> target 2
        chk("R7 irq2 high", 32'(irq), 32'h04);
        rd_chk("R4 claim picks higher priority", 16'h4204, 32'd43);
        rd_chk("R4 claim cleared pending", 16'h1004, 32'd0);
        chk("R7 irq low while claimed", 32'(irq), 32'd0);
        rd_chk("R7 second claim returns 0", 16'h4204, 32'd0);
        rd_chk("R7 second claim clears nothing", 16'h1000, 32'h0000_0408);
        wr32(16'h4204, 32'd11);
        chk("R6 mismatched complete ignored", 32'(irq), 32'd0);
        wr32(16'h4204, 32'd43);
        chk("R6 complete re-enables irq", 32'(irq), 32'h04);
    endtask

    task automatic t_tie;
        wr32(16'h00CC, 32'd1);                     // ID 51 priority equals ID 11
        wr32(16'h2104, 32'h0004_0400);
        wr32(16'h1004, 32'h0004_0000);             // sender 6 -> target 2
        rd_chk("R5 tie picks lower ID", 16'h4204, 32'd11);
        wr32(16'h4204, 32'd11);
        rd_chk("R5 next claim higher ID", 16'h4204, 32'd51);
        wr32(16'h4204, 32'd51);
        rd_chk("R4 empty claim returns 0", 16'h4204, 32'd0);
        chk("R7 irq low when empty", 32'(irq), 32'd0);
    endtask

    task automatic t_redeliver;
        wr32(16'h1000, 32'h0000_0400);
        chk("R7 redelivered", 32'(irq), 32'h04);
        rd_chk("R4 claim again", 16'h4204, 32'd11);
        wr32(16'h1000, 32'h0000_0400);             // raised while its claim is open
        chk("R7 held while claimed", 32'(irq), 32'd0);
        wr32(16'h4204, 32'd11);
        chk("R7 delivered after complete", 32'(irq), 32'h04);
        rd_chk("R4 claim held source", 16'h4204, 32'd11);
        wr32(16'h4204, 32'd11);
        chk("R7 irq idle", 32'(irq), 32'd0);
    endtask

    task automatic t_unmapped;
        wr32(16'h3000, 32'hFFFF_FFFF);
        wr32(16'h1008, 32'hFFFF_FFFF);
        wr32(16'h4200, 32'hFFFF_FFFF);
        wr32(16'h0000, 32'hFFFF_FFFF);
        wr32(16'h2108, 32'hFFFF_FFFF);
        rd_chk("R9 read 0x3000", 16'h3000, 32'd0);
        rd_chk("R9 read pending beyond", 16'h1008, 32'd0);
        rd_chk("R9 read ctx offset 0", 16'h4200, 32'd0);
        rd_chk("R9 read priority ID0", 16'h0000, 32'd0);
        rd_chk("R9 read enable word2", 16'h2108, 32'd0);
        rd_chk("R9 pending unchanged", 16'h1000, 32'h0000_0008);
        rd_chk("R9 priority ID1 unchanged", 16'h0004, 32'd0);
        rd_chk("R9 enable unchanged", 16'h2100, 32'h0000_0400);
        chk("R9 irq unchanged", 32'(irq), 32'd0);
        wr32(16'h002C, 32'hFFFF_FFFF);
        rd_chk("R2 priority width", 16'h002C, 32'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_w1s();
        t_claim();
        t_tie();
        t_redeliver();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule